// File: doc/BRIEF.md
# Hardware Store Request Handshake

This block sits between a shared, active-low store-request line and the nonvolatile store engine of a memory with battery-free backup. The line is wired-AND across several devices: any of them may pull it low to ask for a store, and each device pulls it low itself while its own store is busy. The block synchronizes the line and rejects low glitches shorter than a minimum width. After a qualified request it opens a grace window in which reads go on and an access already in flight may finish, while new writes are refused. At the end of the window it fires a store only if the local array holds data written since the last nonvolatile cycle.

During a store the block drives the shared line low through an open-drain enable. After the store, or at once when there was nothing to store, the device stays disabled until the line is seen high again, and then for a fixed recovery interval. A request that arrives while another nonvolatile cycle is running is dropped, not deferred. The store engine is outside the block: it is started by a one-cycle strobe and reports completion on a done input.

Top module: `storeReqHandshake`

## Requirements
- R1: While reset is held and in the first cycle after reset, storeStart, pullDown, chipDisable and writeInhibit are all 0.
- R2: The line passes through a two-stage synchronizer, and a low level counts as a request only after MIN_PULSE consecutive low samples. A line that goes low before a rising clock edge and stays low opens the request window after edge 2+MIN_PULSE. A low pulse shorter than MIN_PULSE clock cycles has no effect on any output.
- R3: The grace window lasts GRACE_CYCLES cycles. It ends at the first edge at which that count has elapsed and accessBusy is 0, so an access in flight extends the window one cycle per busy cycle.
- R4: From the edge that opens the window until the block returns to idle, writeInhibit equals writeReq. In idle, writeInhibit is 0.
- R5: At the end of the grace window the store is started only if dirty is 1. When dirty is 0, storeStart and pullDown stay 0 for the whole request.
- R6: pullDown is 1 from the cycle in which storeStart is 1 until the edge at which storeDone is sampled 1, and it falls after that edge.
- R7: chipDisable is 1 from the end of the grace window until the synchronized line has been high and then RECOVER_CYCLES further cycles have passed. If the line is released before a rising edge, chipDisable falls after edge 3+RECOVER_CYCLES.
- R8: A request that qualifies while nvOpBusy is 1 is dropped. It is not taken later during the same low period, even after nvOpBusy falls.
- R9: storeStart is a single-cycle pulse, at most one per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Level of the shared active-low store-request line |
| accessBusy | input | 1 | An array read or write cycle is in flight |
| writeReq | input | 1 | A new write to the array is being requested |
| dirty | input | 1 | The array was written since the last store or recall |
| nvOpBusy | input | 1 | Another nonvolatile cycle (store or recall) is running |
| storeDone | input | 1 | The store engine has finished |
| storeStart | output | 1 | One-cycle strobe that starts the store engine |
| pullDown | output | 1 | Open-drain enable pulling the shared line low |
| writeInhibit | output | 1 | The current write request is refused |
| chipDisable | output | 1 | Array access is locked out |

## Verification
Two situations are hard to reach from the ports. The first is a grace window that expires while an access is still in flight. The bench holds accessBusy high past the window by a random number of cycles and checks the exact edge of storeStart. The second is a request that qualifies while another nonvolatile cycle runs and must stay dropped after that cycle ends. A directed case keeps the line low across the fall of nvOpBusy to cover it. The bench models the line as a wired-AND of its own request and the block's pullDown, so the block's own busy pull feeds back into the synchronizer as it would on a shared line.

// File: rtl/storeReqPkg.sv
package storeReqPkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_GRACE   = 3'd1,
    ST_STORE   = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RECOVER = 3'd4
  } hsState_e;

  typedef struct packed {
    logic loadGrace;
    logic loadRecover;
    logic fireStore;
  } dpStrobe_t;

endpackage

// File: rtl/storeReqDatapath.sv
module storeReqDatapath
  import storeReqPkg::*;
#(
  parameter int MIN_PULSE      = 2,
  parameter int GRACE_CYCLES   = 8,
  parameter int RECOVER_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineIn,
  input  dpStrobe_t strobe,
  output logic      reqEvt,
  output logic      lineHigh,
  output logic      graceDone,
  output logic      recoverDone,
  output logic      storeStart
);

  localparam int SYNC_STAGES = 2;
  localparam int LW = $clog2(MIN_PULSE + 1);
  localparam int GW = $clog2(GRACE_CYCLES + 1);
  localparam int RW = $clog2(RECOVER_CYCLES + 1);
  localparam logic [LW-1:0] LOW_LAST  = LW'(MIN_PULSE - 1);
  localparam logic [LW-1:0] LOW_FULL  = LW'(MIN_PULSE);
  localparam logic [GW-1:0] GRACE_TOP = GW'(GRACE_CYCLES - 1);
  localparam logic [RW-1:0] REC_TOP   = RW'(RECOVER_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [LW-1:0]          lowCnt;
  logic [GW-1:0]          graceCnt;
  logic [RW-1:0]          recoverCnt;
  logic                   startQ;

  // metastability guard, reset to the idle (released) level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
  end

  assign lineHigh = syncQ[SYNC_STAGES-1];

  // width qualifier: saturating count of consecutive low samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lowCnt <= '0;
    else if (lineHigh)         lowCnt <= '0;
    else if (lowCnt != LOW_FULL) lowCnt <= lowCnt + 1'b1;
  end

  // single event on the sample that completes the minimum width
  assign reqEvt = !lineHigh && (lowCnt == LOW_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 graceCnt <= '0;
    else if (strobe.loadGrace) graceCnt <= GRACE_TOP;
    else if (graceCnt != '0)   graceCnt <= graceCnt - 1'b1;
  end

  assign graceDone = (graceCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   recoverCnt <= '0;
    else if (strobe.loadRecover) recoverCnt <= REC_TOP;
    else if (recoverCnt != '0)   recoverCnt <= recoverCnt - 1'b1;
  end

  assign recoverDone = (recoverCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startQ <= 1'b0;
    else       startQ <= strobe.fireStore;
  end

  assign storeStart = startQ;

endmodule

// File: rtl/storeReqCtrl.sv
module storeReqCtrl
  import storeReqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqEvt,
  input  logic      lineHigh,
  input  logic      graceDone,
  input  logic      recoverDone,
  input  logic      accessBusy,
  input  logic      dirty,
  input  logic      nvOpBusy,
  input  logic      storeDone,
  output dpStrobe_t strobe,
  output logic      pullDown,
  output logic      chipDisable,
  output logic      blockWrites
);

  hsState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqEvt && !nvOpBusy) begin
          stateNext        = ST_GRACE;
          strobe.loadGrace = 1'b1;
        end
      end
      ST_GRACE: begin
        if (graceDone && !accessBusy) begin
          if (dirty) begin
            stateNext        = ST_STORE;
            strobe.fireStore = 1'b1;
          end else begin
            stateNext = ST_HOLD;
          end
        end
      end
      ST_STORE: begin
        if (storeDone) stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (lineHigh) begin
          stateNext          = ST_RECOVER;
          strobe.loadRecover = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (recoverDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign pullDown    = (state == ST_STORE);
  assign chipDisable = (state == ST_STORE) || (state == ST_HOLD) || (state == ST_RECOVER);
  assign blockWrites = (state != ST_IDLE);

endmodule

// File: rtl/storeReqHandshake.sv
module storeReqHandshake
  import storeReqPkg::*;
#(
  parameter int MIN_PULSE      = 2,
  parameter int GRACE_CYCLES   = 8,
  parameter int RECOVER_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  input  logic accessBusy,
  input  logic writeReq,
  input  logic dirty,
  input  logic nvOpBusy,
  input  logic storeDone,
  output logic storeStart,
  output logic pullDown,
  output logic writeInhibit,
  output logic chipDisable
);

  dpStrobe_t strobe;
  logic reqEvt, lineHigh, graceDone, recoverDone, blockWrites;

  storeReqDatapath #(
    .MIN_PULSE      (MIN_PULSE),
    .GRACE_CYCLES   (GRACE_CYCLES),
    .RECOVER_CYCLES (RECOVER_CYCLES)
  ) dp (
    .clk         (clk),
    .rstN        (rstN),
    .lineIn      (lineIn),
    .strobe      (strobe),
    .reqEvt      (reqEvt),
    .lineHigh    (lineHigh),
    .graceDone   (graceDone),
    .recoverDone (recoverDone),
    .storeStart  (storeStart)
  );

  storeReqCtrl ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqEvt      (reqEvt),
    .lineHigh    (lineHigh),
    .graceDone   (graceDone),
    .recoverDone (recoverDone),
    .accessBusy  (accessBusy),
    .dirty       (dirty),
    .nvOpBusy    (nvOpBusy),
    .storeDone   (storeDone),
    .strobe      (strobe),
    .pullDown    (pullDown),
    .chipDisable (chipDisable),
    .blockWrites (blockWrites)
  );

  assign writeInhibit = writeReq && blockWrites;

endmodule

// File: rtl/storeReqHandshakeChecker.sv
module storeReqHandshakeChecker (
  input logic clk,
  input logic rstN,
  input logic accessBusy,
  input logic writeReq,
  input logic dirty,
  input logic storeDone,
  input logic storeStart,
  input logic pullDown,
  input logic writeInhibit,
  input logic chipDisable
);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |=> !storeStart); // R9

  AST_START_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |-> $past(dirty)); // R5

  AST_START_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |-> !$past(accessBusy)); // R3

  AST_START_WITH_PULL: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |-> pullDown); // R6

  AST_PULL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (pullDown && storeDone) |=> !pullDown); // R6

  AST_PULL_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    pullDown |-> chipDisable); // R7

  AST_INHIBIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    writeInhibit |-> writeReq); // R4

endmodule

bind storeReqHandshake storeReqHandshakeChecker chk (
  .clk          (clk),
  .rstN         (rstN),
  .accessBusy   (accessBusy),
  .writeReq     (writeReq),
  .dirty        (dirty),
  .storeDone    (storeDone),
  .storeStart   (storeStart),
  .pullDown     (pullDown),
  .writeInhibit (writeInhibit),
  .chipDisable  (chipDisable)
);

// File: tb/storeReqHandshake_test.sv
`timescale 1ns/1ps
module storeReqHandshake_test;

  localparam int MINP = 2;
  localparam int GRC  = 8;
  localparam int REC  = 4;
  localparam int RUN  = 80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extLow = 1'b0;
  logic accessBusy = 1'b0, writeReq = 1'b0, dirty = 1'b0;
  logic nvOpBusy = 1'b0, storeDone = 1'b0;
  logic storeStart, pullDown, writeInhibit, chipDisable;
  wire  lineIn = !extLow && !pullDown;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  storeReqHandshake #(.MIN_PULSE(MINP), .GRACE_CYCLES(GRC), .RECOVER_CYCLES(REC)) uut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .accessBusy(accessBusy),
    .writeReq(writeReq), .dirty(dirty), .nvOpBusy(nvOpBusy), .storeDone(storeDone),
    .storeStart(storeStart), .pullDown(pullDown), .writeInhibit(writeInhibit),
    .chipDisable(chipDisable)
  );

  function automatic int windowEdge();
    return 2 + MINP;
  endfunction

  function automatic int startEdge(int extra);
    return 2 + MINP + GRC + extra;
  endfunction

  function automatic bit qualifies(int lowLen);
    return lowLen >= MINP;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // generic request run: line dropped at negedge 0, edges counted from 1
  task automatic runReq(int lowLen, bit dirtyBit, int extra);
    int firstStart = 0;
    int pulses = 0;
    int pullSeen = 0;
    int inhAtWin = 0;
    int expStart;
    dirty = dirtyBit;
    writeReq = 1'b1;
    extLow = 1'b1;
    accessBusy = (startEdge(extra) - 1 > 0);
    expStart = (qualifies(lowLen) && dirtyBit) ? startEdge(extra) : 0;
    for (int n = 1; n <= RUN; n++) begin
      step();
      if (storeStart) begin
        pulses++;
        if (firstStart == 0) firstStart = n;
      end
      if (pullDown) pullSeen++;
      if (n == windowEdge()) inhAtWin = writeInhibit;
      extLow     = (n < lowLen);
      accessBusy = (n < startEdge(extra) - 1);
      storeDone  = (firstStart != 0) && (n == firstStart + 2);
    end
    check(firstStart == expStart, "R3 store start edge", firstStart, expStart);
    check(pulses == (expStart != 0 ? 1 : 0), "R9 single start pulse", pulses, expStart != 0 ? 1 : 0);
    check(inhAtWin == int'(qualifies(lowLen)), "R2 window opens after qualification", inhAtWin, int'(qualifies(lowLen)));
    if (!dirtyBit) check(pullSeen == 0, "R5 no pull when clean", pullSeen, 0);
    check(chipDisable == 1'b0, "R7 lockout ends", chipDisable, 0);
    writeReq = 1'b0;
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    #3;
    check(storeStart == 0 && pullDown == 0 && chipDisable == 0 && writeInhibit == 0,
          "R1 outputs in reset", {storeStart, pullDown, chipDisable, writeInhibit}, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    check({storeStart, pullDown, chipDisable, writeInhibit} == 4'b0,
          "R1 outputs after reset", {storeStart, pullDown, chipDisable, writeInhibit}, 0);

    // directed dirty store with full lockout timing
    dirty = 1'b1; writeReq = 1'b1; extLow = 1'b1;
    for (int n = 1; n <= windowEdge() - 1; n++) step();
    check(writeInhibit == 1'b0, "R4 no inhibit before window", writeInhibit, 0);
    step();
    check(writeInhibit == 1'b1, "R4 inhibit in window", writeInhibit, 1);
    for (int n = windowEdge() + 1; n <= startEdge(0) - 1; n++) step();
    check(storeStart == 1'b0, "R3 no start before grace end", storeStart, 0);
    step();
    check(storeStart == 1'b1, "R3 start at grace end", storeStart, 1);
    check(pullDown == 1'b1, "R6 pull with start", pullDown, 1);
    check(chipDisable == 1'b1, "R7 disabled at start", chipDisable, 1);
    step();
    check(storeStart == 1'b0, "R9 start is one cycle", storeStart, 0);
    check(pullDown == 1'b1, "R6 pull held during store", pullDown, 1);
    storeDone = 1'b1;
    step();
    storeDone = 1'b0;
    check(pullDown == 1'b0, "R6 pull released after done", pullDown, 0);
    for (int n = 0; n < 10; n++) step();
    check(chipDisable == 1'b1, "R7 disabled while line low", chipDisable, 1);
    extLow = 1'b0;
    for (int n = 1; n <= 2 + REC; n++) step();
    check(chipDisable == 1'b1, "R7 still in recovery", chipDisable, 1);
    step();
    check(chipDisable == 1'b0, "R7 recovery over", chipDisable, 0);
    check(writeInhibit == 1'b0, "R4 inhibit cleared in idle", writeInhibit, 0);
    for (int n = 0; n < 4; n++) step();

    // clean: no store, still locked out
    runReq(30, 1'b0, 0);
    // short glitch ignored
    begin
      int seen = 0;
      writeReq = 1'b1; dirty = 1'b1; extLow = 1'b1;
      for (int n = 1; n <= 30; n++) begin
        step();
        if (n >= MINP - 1) extLow = 1'b0;
        if (writeInhibit || chipDisable || storeStart) seen++;
      end
      check(seen == 0, "R2 short pulse ignored", seen, 0);
      writeReq = 1'b0;
    end
    // access in flight stretches grace
    runReq(40, 1'b1, 3);
    // exact minimum width accepted
    runReq(MINP, 1'b1, 0);

    // request during another nonvolatile cycle is dropped
    begin
      int seen = 0;
      nvOpBusy = 1'b1; writeReq = 1'b1; dirty = 1'b1; extLow = 1'b1;
      for (int n = 1; n <= 40; n++) begin
        step();
        if (n == windowEdge() + 2) nvOpBusy = 1'b0;
        if (writeInhibit || storeStart || chipDisable) seen++;
      end
      check(seen == 0, "R8 request dropped while busy", seen, 0);
      extLow = 1'b0; writeReq = 1'b0;
      for (int n = 0; n < 6; n++) step();
    end

    // constrained random mix
    for (int i = 0; i < 30; i++) begin
      int lens[5] = '{1, 2, 3, 5, 40};
      int lowLen = lens[$urandom_range(0, 4)];
      bit d = 1'($urandom_range(0, 1));
      int extra = $urandom_range(0, 3);
      runReq(lowLen, d, extra);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule